// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Register

This block holds the interrupt status of a real-time clock. Three event sources feed it. The first is a level taken from a divider tap, whose rising edge marks a periodic tick. The second is a single-cycle pulse when the alarm time matches. The third is a single-cycle pulse when a time update completes. Each event latches its own flag, whatever the state of the matching enable. A flag stays set until the status register is read or the block is reset.

Three enable bits come from a control register that lives outside the block. A flag raises the combined request only when its enable is also set. The combined request drives an active-low interrupt pin. A small read port returns one of two registers. Address 0 is the flag status register, and reading it clears the three flags. Address 1 is a validity register whose top bit always reads 1.

Top module: `rtc_irq_status`

## Requirements
- R1: A synchronous active-high `rst` clears the periodic, alarm and update flags and the combined request. In the cycle after a reset edge, `irq_n` is 1 and a status read returns 8'h00.
- R2: A rising edge on `tick_lvl` sets the periodic flag (status bit 6), whatever `en_per` holds. Holding `tick_lvl` high produces no further sets. After the flag is cleared, it stays 0 until the next rising edge.
- R3: An `alarm_hit` pulse sets the alarm flag (status bit 5), whatever `en_alm` holds.
- R4: An `upd_done` pulse sets the update flag (status bit 4), whatever `en_upd` holds.
- R5: The combined request (status bit 7) becomes 1 on the clock edge after any flag and its matching enable are both 1. While the combined request is 1, `irq_n` is 0. There is one cycle of latency from flag to pin.
- R6: With `rd_en` high and `rd_addr`=0, `rd_data` holds {request, periodic, alarm, update, 4'b0000} one edge later. These are the values from before the read, and bits 3..0 are always 0. The same edge clears all three flags.
- R7: An event that arrives in the same cycle as a clearing status read leaves its flag set. The data returned by that read does not show the event.
- R8: A read with `rd_addr`=1 returns 8'h80 one edge later, including while `rst` is high. This read does not change any flag.
- R9: `irq_n` returns to 1 one edge after no enabled flag remains set. This happens when the flags are cleared or when the enables are dropped. A flag whose enable is 0 never pulls `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_lvl | input | 1 | Divider tap level; a rising edge is a periodic event |
| alarm_hit | input | 1 | Single-cycle alarm match pulse |
| upd_done | input | 1 | Single-cycle update complete pulse |
| en_per | input | 1 | Periodic interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_upd | input | 1 | Update interrupt enable |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 selects the status register, 1 selects the validity register |
| rd_data | output | 8 | Read data, valid one edge after the strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest situation to create is an event that lands in the same cycle as a clearing status read. In that cycle, the returned data must miss the event while the flag keeps it. The driver raises `rd_en` and `upd_done` on the same falling edge. The scoreboard expects 8'h00 from that read and 8'h10 from the read that follows. A second case is an enable that drops while its flag stays latched. In that case the pin must release even though a later read still shows the flag.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int REG_W    = 8;
  localparam int SRC_N    = 3;
  localparam int LOW_ZERO = REG_W - 1 - SRC_N;

  // flag vector order {periodic, alarm, update} lands in status bits 6..4
  localparam int FI_UPD = 0;
  localparam int FI_ALM = 1;
  localparam int FI_PER = 2;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_VALID  = 1'b1;

  function automatic logic fn_request(input logic [SRC_N-1:0] flags,
                                      input logic [SRC_N-1:0] en);
    return |(flags & en);
  endfunction

  function automatic logic [REG_W-1:0] fn_status_word(input logic req,
                                                      input logic [SRC_N-1:0] flags);
    return {req, flags, {LOW_ZERO{1'b0}}};
  endfunction

  function automatic logic [REG_W-1:0] fn_valid_word();
    return {1'b1, {(REG_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/rtc_tap_edge.sv
module rtc_tap_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    // during reset track the level so no false edge follows
    lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q & ~rst;
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst)         f_q <= 1'b0;
      else if (evt[i]) f_q <= 1'b1;   // event wins over a same-cycle clear
      else if (clr)    f_q <= 1'b0;
    end
    assign flags[i] = f_q;
  end
endmodule

// File: rtl/rtc_irq_reduce.sv
module rtc_irq_reduce
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] flags,
  input  logic [SRC_N-1:0] en,
  output logic             req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= fn_request(flags, en);
  end
endmodule

// File: rtl/rtc_status_port.sv
module rtc_status_port
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rd_en,
  input  logic             rd_addr,
  input  logic             req,
  input  logic [SRC_N-1:0] flags,
  output logic [REG_W-1:0] rd_data,
  output logic             clr
);
  logic [REG_W-1:0] rd_q;

  assign clr = rd_en & (rd_addr == ADDR_STATUS);

  always_ff @(posedge clk) begin
    if (rd_en) begin
      if (rd_addr == ADDR_VALID) rd_q <= fn_valid_word();
      else                       rd_q <= fn_status_word(req, flags);
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_lvl,
  input  logic             alarm_hit,
  input  logic             upd_done,
  input  logic             en_per,
  input  logic             en_alm,
  input  logic             en_upd,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_n
);
  // named internal events, visible to the checker
  logic             per_evt;
  logic [SRC_N-1:0] evt_vec;
  logic [SRC_N-1:0] en_vec;
  logic [SRC_N-1:0] flag_vec;
  logic             rd_clear;
  logic             req_q;

  rtc_tap_edge u_tap (
    .clk (clk),
    .rst (rst),
    .lvl (tick_lvl),
    .rise(per_evt)
  );

  always_comb begin
    evt_vec         = '0;
    evt_vec[FI_PER] = per_evt;
    evt_vec[FI_ALM] = alarm_hit;
    evt_vec[FI_UPD] = upd_done;
    en_vec          = '0;
    en_vec[FI_PER]  = en_per;
    en_vec[FI_ALM]  = en_alm;
    en_vec[FI_UPD]  = en_upd;
  end

  rtc_flag_bank #(.N(SRC_N)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .evt  (evt_vec),
    .clr  (rd_clear),
    .flags(flag_vec)
  );

  rtc_irq_reduce u_req (
    .clk  (clk),
    .rst  (rst),
    .flags(flag_vec),
    .en   (en_vec),
    .req_q(req_q)
  );

  rtc_status_port u_port (
    .clk    (clk),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .req    (req_q),
    .flags  (flag_vec),
    .rd_data(rd_data),
    .clr    (rd_clear)
  );

  assign irq_n = ~req_q;
endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk
  import rtc_irq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [SRC_N-1:0] evt_vec,
  input logic [SRC_N-1:0] en_vec,
  input logic [SRC_N-1:0] flag_vec,
  input logic             rd_en,
  input logic             rd_addr,
  input logic [REG_W-1:0] rd_data,
  input logic             irq_n
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flag_vec == '0 && irq_n));

  a_r2_periodic_sets: assert property (@(posedge clk) disable iff (rst)
    evt_vec[FI_PER] |=> flag_vec[FI_PER]);

  a_r3_alarm_sets: assert property (@(posedge clk) disable iff (rst)
    evt_vec[FI_ALM] |=> flag_vec[FI_ALM]);

  a_r4_update_sets: assert property (@(posedge clk) disable iff (rst)
    evt_vec[FI_UPD] |=> flag_vec[FI_UPD]);

  a_r5_pin_asserts: assert property (@(posedge clk) disable iff (rst)
    (|(flag_vec & en_vec)) |=> !irq_n);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_STATUS && evt_vec == '0) |=> flag_vec == '0);

  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[LOW_ZERO-1:0] == '0);

  a_r7_event_survives: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_STATUS && evt_vec[FI_UPD]) |=> flag_vec[FI_UPD]);

  a_r8_valid_word: assert property (@(posedge clk)
    (rd_en && rd_addr == ADDR_VALID) |=> rd_data == 8'h80);

  a_r8_no_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_VALID) |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

  a_r9_pin_releases: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_vec & en_vec)) |=> irq_n);
endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .evt_vec (evt_vec),
  .en_vec  (en_vec),
  .flag_vec(flag_vec),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .irq_n   (irq_n)
);

// File: tb/rtc_irq_status_test.sv
module rtc_irq_status_test;
  logic clk = 0, rst = 1;
  logic tick_lvl = 0, alarm_hit = 0, upd_done = 0;
  logic en_per = 0, en_alm = 0, en_upd = 0;
  logic rd_en = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic irq_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  rtc_irq_status uut (
    .clk(clk), .rst(rst), .tick_lvl(tick_lvl), .alarm_hit(alarm_hit),
    .upd_done(upd_done), .en_per(en_per), .en_alm(en_alm), .en_upd(en_upd),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // driver: one read, expectation pushed to the scoreboard
  task automatic do_read(logic addr, logic [7:0] exp, string tag);
    rd_en = 1; rd_addr = addr;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic pin(logic exp, string tag);
    chk(tag, {7'b0, irq_n}, {7'b0, exp});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare data one edge after each strobe
  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      if (exp_q.size() == 0) chk("scoreboard underflow", 8'hFF, 8'h00);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    idle(3);
    pin(1, "R1 pin high in reset");
    do_read(1, 8'h80, "R8 valid read during reset");
    rst = 0;
    do_read(0, 8'h00, "R1 status after reset");

    // disabled alarm: flag latches, pin stays high
    alarm_hit = 1; @(negedge clk); alarm_hit = 0;
    idle(2);
    pin(1, "R9 disabled flag keeps pin high");
    do_read(0, 8'h20, "R3 alarm flag latched");
    do_read(0, 8'h00, "R6 read cleared flags");

    // periodic edge, level held
    tick_lvl = 1; idle(2);
    do_read(0, 8'h40, "R2 periodic edge");
    idle(2);
    do_read(0, 8'h00, "R2 held level no retrigger");
    tick_lvl = 0; idle(1); tick_lvl = 1; idle(1);
    do_read(0, 8'h40, "R2 second edge");

    // enabled update: latency and release
    en_upd = 1;
    upd_done = 1; @(negedge clk); upd_done = 0;
    pin(1, "R5 one cycle latency");
    @(negedge clk);
    pin(0, "R5 pin low");
    do_read(0, 8'h90, "R4 R6 update and request");
    pin(0, "R9 pin held one edge after clear");
    @(negedge clk);
    pin(1, "R9 pin released after clear");
    en_upd = 0;

    // enable dropped while flag latched
    en_alm = 1;
    alarm_hit = 1; @(negedge clk); alarm_hit = 0;
    idle(1);
    pin(0, "R5 alarm pin low");
    en_alm = 0; @(negedge clk);
    pin(1, "R9 pin releases on enable drop");
    do_read(0, 8'h20, "R9 flag still latched");

    // event in the clearing read cycle
    upd_done = 1; rd_en = 1; rd_addr = 0;
    exp_q.push_back(8'h00); tag_q.push_back("R7 read misses same-cycle event");
    @(negedge clk);
    upd_done = 0; rd_en = 0;
    do_read(0, 8'h10, "R7 same-cycle event kept");

    // validity read does not clear
    alarm_hit = 1; @(negedge clk); alarm_hit = 0;
    do_read(1, 8'h80, "R8 valid word");
    do_read(0, 8'h20, "R8 valid read left flag");

    // all three together
    en_per = 1; en_alm = 1; en_upd = 1;
    tick_lvl = 0; idle(1);
    tick_lvl = 1; alarm_hit = 1; upd_done = 1; @(negedge clk);
    alarm_hit = 0; upd_done = 0;
    idle(1);
    pin(0, "R5 all sources");
    do_read(0, 8'hF0, "R5 R6 all flags");

    // reset clears latched enabled flag
    alarm_hit = 1; @(negedge clk); alarm_hit = 0;
    idle(1);
    pin(0, "R5 before reset");
    rst = 1; @(negedge clk); rst = 0;
    pin(1, "R1 pin high after reset");
    do_read(0, 8'h00, "R1 flags cleared by reset");
    do_read(1, 8'h80, "R8 valid after reset");
    idle(2);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) chk("watchdog expired", 8'h01, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule